// File: doc/BRIEF.md
# Branch History Trace Encoder

This block watches the stream of retired instructions from a processor core and turns it into program-trace messages. Each accepted event names an instruction class, a taken or executed flag, a pair of predicate outcomes and a target address. A mode input picks between two ways of tracing. In traditional mode, every taken direct or indirect branch produces its own message. That message carries the number of instructions retired since the previous message. In history mode, predicated outcomes and direct-branch outcomes are shifted into a history field. A message is produced only when an indirect transfer is taken.

The history field is a 32-bit word with a leading stop bit, so it can hold up to 31 outcome bits. The instruction counter is 8 bits wide. When either one would overflow, the block emits a resource-full message and starts a fresh window. Messages leave through a valid/ready handshake. The `busy` output stays high while a message is pending, and the event source must hold its event until `busy` falls.

Top module: `bht_trace_encoder`

## Requirements
- R1: After reset, `msg_valid` and `busy` are 0, the history holds only its stop bit (32'h1) and the instruction count is 0.
- R2: In history mode (`mode_hist`=1), a predicated event (class 1) or a direct-branch event (class 3) shifts one bit in at bit 0, older bits moving up, with the stop bit above the oldest bit. The bit is 1 when `ev_taken` is 1 and 0 otherwise.
- R3: In history mode, a paired-predicate event (class 2) shifts in two bits in one event. `ev_pair[1]` lands in the older (higher) position and `ev_pair[0]` in bit 0.
- R4: In history mode, a taken register-target branch (class 5) or a taken trap or system call (class 6) emits a message. So does any return from interrupt (class 7), whatever `ev_taken` is. The message has type 3 and carries the count, the history and `ev_target`. The history then returns to 32'h1 and the count to 0.
- R5: In history mode, direct branches (class 3) and instruction-synchronize events (class 4) emit no message. An instruction-synchronize event shifts in a 1.
- R6: In traditional mode (`mode_hist`=0), a taken direct branch (class 3) or an instruction-synchronize event (class 4) emits type 1. A taken indirect event emits type 2. Both carry the count, history 32'h1 and `ev_target`. Predicated and paired events only add to the count.
- R7: The count in a message equals the number of events accepted since the previous message, not counting the event that triggers it. The count is reset by every message.
- R8: An event whose history bits would overflow the 31-bit capacity emits a resource-full message instead (type 4). It carries the history before that event, the count and target 0. The event's bits then start a new history, and the count restarts at 1.
- R9: A non-messaging event accepted while the count is 255 emits a resource-full message (type 4) with count 255, and the count restarts at 1. A branch message at count 255 carries 255 with no extra message.
- R10: When count saturation and history overflow meet in one event, exactly one resource-full message is emitted.
- R11: `msg_data` = {type[2:0], count[7:0], history[31:0], target[31:0]} stays stable while `msg_valid` is high and `msg_ready` is low. `busy` is high exactly while a message is pending, and `msg_valid` drops in the cycle after a handshake.
- R12: Events offered while `busy` is high are ignored and do not change the count or the history.
- R13: An untaken register-target branch (class 5) or an untaken trap (class 6) counts as a sequential instruction. It emits no message and adds no history bit. A sequential event is class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_hist | input | 1 | 1 = history mode, 0 = traditional mode |
| ev_valid | input | 1 | Retired-instruction event present |
| ev_class | input | 3 | Instruction class code (0..7) |
| ev_taken | input | 1 | Branch taken / predicate executed |
| ev_pair | input | 2 | Two predicate outcomes for class 2 |
| ev_target | input | 32 | Target address of the transfer |
| busy | output | 1 | Message pending; events not accepted |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer takes the message |
| msg_data | output | 75 | {type, count, history, target} |

## Verification
The two overflow paths can fire on the same event: the count is already at 255 and the history already holds 31 bits when one more predicated event arrives. The bench reaches this with 31 predicated events followed by 224 sequential ones, then adds a predicated 0. It expects a single type-4 message with count 255 and an all-ones history. It then confirms that no second message appears, and that the following indirect message shows count 1 and history 32'h2. Two other cases are placed at their edges: an indirect transfer that arrives with a completely full history, and a branch at count 255.

// File: rtl/bht_pkg.sv
package bht_pkg;

  typedef enum logic [2:0] {
    EVC_SEQ    = 3'd0,
    EVC_PRED   = 3'd1,
    EVC_PAIR   = 3'd2,
    EVC_DIRECT = 3'd3,
    EVC_ISYNC  = 3'd4,
    EVC_REGBR  = 3'd5,
    EVC_TRAP   = 3'd6,
    EVC_RETURN = 3'd7
  } ev_class_e;

  typedef enum logic [2:0] {
    MT_NONE     = 3'd0,
    MT_DIRECT   = 3'd1,
    MT_INDIRECT = 3'd2,
    MT_HIST_IND = 3'd3,
    MT_RES_FULL = 3'd4
  } msg_type_e;

  localparam int TYPE_W = 3;

endpackage

// File: rtl/bht_classify.sv
module bht_classify
  import bht_pkg::*;
(
  input  logic [2:0] cls_i,
  input  logic       taken_i,
  input  logic [1:0] pair_i,
  input  logic       mode_hist_i,
  output logic [1:0] app_n_o,
  output logic [1:0] app_bits_o,
  output logic       ind_take_o,
  output logic       dir_take_o
);

  ev_class_e cls;
  assign cls = ev_class_e'(cls_i);

  always_comb begin
    app_n_o    = 2'd0;
    app_bits_o = 2'b00;
    ind_take_o = 1'b0;
    dir_take_o = 1'b0;
    case (cls)
      EVC_PRED: begin
        if (mode_hist_i) begin
          app_n_o    = 2'd1;
          app_bits_o = {1'b0, taken_i};
        end
      end
      EVC_PAIR: begin
        if (mode_hist_i) begin
          app_n_o    = 2'd2;
          app_bits_o = pair_i;
        end
      end
      EVC_DIRECT: begin
        dir_take_o = taken_i;
        if (mode_hist_i) begin
          app_n_o    = 2'd1;
          app_bits_o = {1'b0, taken_i};
        end
      end
      EVC_ISYNC: begin
        dir_take_o = 1'b1;
        if (mode_hist_i) begin
          app_n_o    = 2'd1;
          app_bits_o = 2'b01;
        end
      end
      EVC_REGBR,
      EVC_TRAP:   ind_take_o = taken_i;
      EVC_RETURN: ind_take_o = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/bht_history.sv
module bht_history #(
  parameter int HIST_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              restart_i,
  input  logic              app_i,
  input  logic [1:0]        app_n_i,
  input  logic [1:0]        app_bits_i,
  output logic [HIST_W-1:0] hist_o,
  output logic              over_o
);

  localparam logic [HIST_W-1:0] STOP = {{(HIST_W-1){1'b0}}, 1'b1};

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] shifted;
  logic [HIST_W-1:0] fresh;

  always_comb begin
    over_o = 1'b0;
    if (app_n_i == 2'd1) over_o = hist_q[HIST_W-1];
    else if (app_n_i == 2'd2) over_o = |hist_q[HIST_W-1:HIST_W-2];
  end

  always_comb begin
    shifted = hist_q;
    fresh   = STOP;
    if (app_n_i == 2'd1) begin
      shifted = {hist_q[HIST_W-2:0], app_bits_i[0]};
      fresh   = {{(HIST_W-2){1'b0}}, 1'b1, app_bits_i[0]};
    end else if (app_n_i == 2'd2) begin
      shifted = {hist_q[HIST_W-3:0], app_bits_i};
      fresh   = {{(HIST_W-3){1'b0}}, 1'b1, app_bits_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= STOP;
    end else if (clr_i) begin
      hist_q <= STOP;
    end else if (restart_i) begin
      hist_q <= fresh;
    end else if (app_i) begin
      hist_q <= shifted;
    end
  end

  assign hist_o = hist_q;

  AST_STOP_PRESENT: assert property (@(posedge clk) disable iff (rst)
    hist_q != '0); // R2

  AST_APPEND_FITS: assert property (@(posedge clk) disable iff (rst)
    (app_i && !clr_i && !restart_i) |-> !over_o); // R8

endmodule

// File: rtl/bht_icount.sv
module bht_icount #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             clr_i,
  input  logic             set_one_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);

  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (set_one_i) begin
      cnt_q <= ONE;
    end else if (inc_i && cnt_q != CMAX) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CMAX);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full_o && inc_i) |-> 1'b0); // R9

endmodule

// File: rtl/bht_msg_reg.sv
module bht_msg_reg #(
  parameter int DATA_W = 75
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);

  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load_i && !valid_q) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
    end else if (valid_q && ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !ready_i) |=> (valid_q && $stable(data_q))); // R11

  AST_NO_LOAD_PENDING: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !valid_q); // R11

endmodule

// File: rtl/bht_trace_encoder.sv
module bht_trace_encoder
  import bht_pkg::*;
#(
  parameter int HIST_W = 32,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 32,
  localparam int DATA_W = TYPE_W + CNT_W + HIST_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_hist,
  input  logic              ev_valid,
  input  logic [2:0]        ev_class,
  input  logic              ev_taken,
  input  logic [1:0]        ev_pair,
  input  logic [ADDR_W-1:0] ev_target,
  output logic              busy,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [DATA_W-1:0] msg_data
);

  logic [1:0]        app_n;
  logic [1:0]        app_bits;
  logic              ind_take;
  logic              dir_take;
  logic [HIST_W-1:0] hist;
  logic              hist_over;
  logic [CNT_W-1:0]  cnt;
  logic              cnt_full;
  logic              accept;
  logic              msg_now;
  logic              spill;
  logic              load;
  msg_type_e         mtype;
  logic [ADDR_W-1:0] mtarget;

  bht_classify u_classify (
    .cls_i       (ev_class),
    .taken_i     (ev_taken),
    .pair_i      (ev_pair),
    .mode_hist_i (mode_hist),
    .app_n_o     (app_n),
    .app_bits_o  (app_bits),
    .ind_take_o  (ind_take),
    .dir_take_o  (dir_take)
  );

  assign busy    = msg_valid;
  assign accept  = ev_valid && !busy;
  assign msg_now = ind_take || (dir_take && !mode_hist);
  assign spill   = !msg_now && (cnt_full || hist_over);
  assign load    = accept && (msg_now || spill);

  always_comb begin
    mtype   = MT_RES_FULL;
    mtarget = '0;
    if (ind_take) begin
      mtype   = mode_hist ? MT_HIST_IND : MT_INDIRECT;
      mtarget = ev_target;
    end else if (msg_now) begin
      mtype   = MT_DIRECT;
      mtarget = ev_target;
    end
  end

  bht_history #(.HIST_W(HIST_W)) u_history (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (accept && msg_now),
    .restart_i  (accept && spill),
    .app_i      (accept && !msg_now && !spill && (app_n != 2'd0)),
    .app_n_i    (app_n),
    .app_bits_i (app_bits),
    .hist_o     (hist),
    .over_o     (hist_over)
  );

  bht_icount #(.CNT_W(CNT_W)) u_icount (
    .clk       (clk),
    .rst       (rst),
    .inc_i     (accept && !msg_now && !spill),
    .clr_i     (accept && msg_now),
    .set_one_i (accept && spill),
    .cnt_o     (cnt),
    .full_o    (cnt_full)
  );

  bht_msg_reg #(.DATA_W(DATA_W)) u_msg (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .data_i  ({mtype, cnt, hist, mtarget}),
    .ready_i (msg_ready),
    .valid_o (msg_valid),
    .data_o  (msg_data)
  );

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(cnt) && $stable(hist))); // R12

  AST_RF_NO_TARGET: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_data[DATA_W-1 -: TYPE_W] == MT_RES_FULL)
      |-> (msg_data[ADDR_W-1:0] == '0)); // R8

  AST_CNT_AFTER_MSG: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> (cnt <= CNT_W'(1))); // R7

  AST_TRAD_NO_HIST: assert property (@(posedge clk) disable iff (rst)
    (accept && !mode_hist) |=> $stable(hist) || (hist == HIST_W'(1))); // R6

endmodule

// File: tb/bht_trace_encoder_bench.sv
module bht_trace_encoder_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_hist = 1'b1;
  logic        ev_valid = 1'b0;
  logic [2:0]  ev_class = 3'd0;
  logic        ev_taken = 1'b0;
  logic [1:0]  ev_pair = 2'b00;
  logic [31:0] ev_target = '0;
  logic        busy;
  logic        msg_valid;
  logic        msg_ready = 1'b0;
  logic [74:0] msg_data;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  bht_trace_encoder u_bht_trace_encoder (
    .clk       (clk),
    .rst       (rst),
    .mode_hist (mode_hist),
    .ev_valid  (ev_valid),
    .ev_class  (ev_class),
    .ev_taken  (ev_taken),
    .ev_pair   (ev_pair),
    .ev_target (ev_target),
    .busy      (busy),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_data  (msg_data)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input int cls, input bit tk, input logic [1:0] pr, input logic [31:0] tgt);
    while (busy) @(negedge clk);
    ev_class  = cls[2:0];
    ev_taken  = tk;
    ev_pair   = pr;
    ev_target = tgt;
    ev_valid  = 1'b1;
    @(negedge clk);
    ev_valid  = 1'b0;
  endtask

  task automatic expect_msg(input string req, input int typ, input int cnt,
                            input logic [31:0] h, input logic [31:0] tgt);
    int w = 0;
    while (!msg_valid && w < 20) begin
      @(negedge clk);
      w++;
    end
    chk(req, {msg_valid, msg_data}, {1'b1, typ[2:0], cnt[7:0], h, tgt});
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
    chk({req, "/R11"}, {msg_valid, busy}, 2'b00);
  endtask

  task automatic quiet(input string req);
    chk(req, msg_valid, 1'b0);
  endtask

  task automatic seqs(input int n);
    for (int i = 0; i < n; i++) send(0, 1'b0, 2'b00, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset, empty history and zero count
    chk("R1", {msg_valid, busy}, 2'b00);
    mode_hist = 1'b1;
    send(6, 1'b1, 2'b00, 32'hA0);
    expect_msg("R1", 3, 0, 32'h1, 32'hA0);

    // R2 R4 R7: sweep 0..31 predicated bits, then an indirect branch
    for (int n = 0; n <= 31; n++) begin
      exp = 32'h1;
      for (int i = 0; i < n; i++) begin
        bit b = ((n + i) % 3 == 0);
        send(1, b, 2'b00, 32'h0);
        exp = {exp[30:0], b};
      end
      send(5, 1'b1, 2'b00, 32'h1000 + n);
      expect_msg("R2_R4_R7", 3, n, exp, 32'h1000 + n);
    end

    // R8: history overflow on 32nd bit
    for (int i = 0; i < 31; i++) send(1, 1'b1, 2'b00, 32'h0);
    send(1, 1'b0, 2'b00, 32'h55);
    expect_msg("R8", 4, 31, 32'hFFFF_FFFF, 32'h0);
    send(7, 1'b0, 2'b00, 32'h200);
    expect_msg("R8", 3, 1, 32'h2, 32'h200);

    // R3: paired predicates sweep
    for (int k = 0; k <= 15; k++) begin
      exp = 32'h1;
      for (int i = 0; i < k; i++) begin
        logic [1:0] p = 2'((i + k) % 4);
        send(2, 1'b0, p, 32'h0);
        exp = {exp[29:0], p};
      end
      send(6, 1'b1, 2'b00, 32'h3000 + k);
      expect_msg("R3", 3, k, exp, 32'h3000 + k);
    end
    // R3 R8: pair that cannot fit at 30 bits held
    exp = 32'h1;
    for (int i = 0; i < 15; i++) begin
      send(2, 1'b0, 2'b01, 32'h0);
      exp = {exp[29:0], 2'b01};
    end
    send(2, 1'b0, 2'b10, 32'h0);
    expect_msg("R3_R8", 4, 15, exp, 32'h0);
    send(5, 1'b1, 2'b00, 32'h44);
    expect_msg("R3_R8", 3, 1, 32'h6, 32'h44);
    // R3: pair fills exactly 31 bits
    exp = 32'h1;
    for (int i = 0; i < 29; i++) begin
      send(1, 1'b1, 2'b00, 32'h0);
      exp = {exp[30:0], 1'b1};
    end
    send(2, 1'b0, 2'b01, 32'h0);
    exp = {exp[29:0], 2'b01};
    quiet("R3");
    send(7, 1'b1, 2'b00, 32'h48);
    expect_msg("R3", 3, 30, exp, 32'h48);

    // R5: direct branches and isync silent in history mode
    send(3, 1'b1, 2'b00, 32'h10);
    quiet("R5");
    send(3, 1'b0, 2'b00, 32'h14);
    quiet("R5");
    send(4, 1'b0, 2'b00, 32'h18);
    quiet("R5");
    send(7, 1'b0, 2'b00, 32'h50);
    expect_msg("R5", 3, 3, 32'hD, 32'h50);

    // R13: untaken indirect-class events in history mode
    seqs(2);
    send(5, 1'b0, 2'b00, 32'h0);
    quiet("R13");
    send(6, 1'b0, 2'b00, 32'h0);
    quiet("R13");
    send(1, 1'b1, 2'b00, 32'h0);
    send(6, 1'b1, 2'b00, 32'h60);
    expect_msg("R13", 3, 5, 32'h3, 32'h60);

    // R6: traditional mode
    mode_hist = 1'b0;
    for (int k = 0; k <= 6; k++) begin
      for (int i = 0; i < k; i++) send(i % 3, 1'b1, 2'b11, 32'h0);
      send(3, 1'b1, 2'b00, 32'h700 + k);
      expect_msg("R6", 1, k, 32'h1, 32'h700 + k);
    end
    send(4, 1'b0, 2'b00, 32'h80);
    expect_msg("R6", 1, 0, 32'h1, 32'h80);
    send(3, 1'b0, 2'b00, 32'h0);
    quiet("R6");
    send(6, 1'b1, 2'b00, 32'h84);
    expect_msg("R6", 2, 1, 32'h1, 32'h84);
    send(5, 1'b0, 2'b00, 32'h0);
    quiet("R13");
    send(7, 1'b0, 2'b00, 32'h88);
    expect_msg("R6_R13", 2, 1, 32'h1, 32'h88);

    // R9: count saturation
    seqs(255);
    send(3, 1'b1, 2'b00, 32'h90);
    expect_msg("R9", 1, 255, 32'h1, 32'h90);
    seqs(256);
    expect_msg("R9", 4, 255, 32'h1, 32'h0);
    send(5, 1'b1, 2'b00, 32'h94);
    expect_msg("R9", 2, 1, 32'h1, 32'h94);
    mode_hist = 1'b1;
    seqs(255);
    send(1, 1'b1, 2'b00, 32'h0);
    expect_msg("R9", 4, 255, 32'h1, 32'h0);
    send(5, 1'b1, 2'b00, 32'h98);
    expect_msg("R9", 3, 1, 32'h3, 32'h98);

    // R10: both overflow causes in one event
    for (int i = 0; i < 31; i++) send(1, 1'b1, 2'b00, 32'h0);
    seqs(224);
    quiet("R10");
    send(1, 1'b0, 2'b00, 32'h0);
    expect_msg("R10", 4, 255, 32'hFFFF_FFFF, 32'h0);
    quiet("R10");
    send(6, 1'b1, 2'b00, 32'h9C);
    expect_msg("R10", 3, 1, 32'h2, 32'h9C);

    // R11 R12: hold with ready low, events offered while busy
    send(1, 1'b1, 2'b00, 32'h0);
    send(1, 1'b1, 2'b00, 32'h0);
    send(5, 1'b1, 2'b00, 32'hB0);
    ev_class = 3'd1;
    ev_taken = 1'b1;
    ev_valid = 1'b1;
    for (int h = 0; h < 4; h++) begin
      chk("R11", {msg_valid, busy, msg_data}, {2'b11, 3'd3, 8'd2, 32'h7, 32'hB0});
      @(negedge clk);
    end
    ev_valid = 1'b0;
    expect_msg("R11", 3, 2, 32'h7, 32'hB0);
    send(6, 1'b1, 2'b00, 32'hB4);
    expect_msg("R12", 3, 0, 32'h1, 32'hB4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end

endmodule